// File: doc/BRIEF.md
# Output Port Synchronizer with Read Timeout

This block sits between the packet controller of a one-to-four router and the four output queues. When the controller flags that the current byte is a header, the block captures the destination port from the byte's two low bits and keeps it until the next header. Every write request from the controller is then steered to that one queue. The full flag of that queue is handed back to the controller as a single full indication.

For each output, the block raises a valid line whenever that queue holds data. A per-port watchdog counts the cycles in which valid is high and the receiver does not read. When ten such cycles pass in a row, the block raises a one-cycle flush pulse so the stale queue is emptied and the router does not stall.

Top module: `port_sync`

## Requirements
- R1: A synchronous active-low reset sets the held destination to port 0 and clears every watchdog count. While reset is low and in the cycle after it, no flush pulse is high.
- R2: The destination is loaded from `hdr_addr` (the header's two low bits, binary port number) at a rising clock edge where `addr_strobe` is high. At every other edge it keeps its value.
- R3: `fifo_we` is one-hot at bit index equal to the held destination while `wr_req` is high, and all zero while `wr_req` is low.
- R4: `full_out` equals the `fifo_full` bit of the held destination.
- R5: `vld_out[i]` is the inverse of `fifo_empty[i]` in the same cycle.
- R6: If `vld_out[i]` is high and `rd_en[i]` is low at ten consecutive rising edges, `flush[i]` is high in the cycle after the tenth edge. Fewer than ten such edges produce no flush.
- R7: An edge with `rd_en[i]` high restarts the ten-edge window of port i.
- R8: An edge with `vld_out[i]` low restarts the ten-edge window of port i.
- R9: A flush pulse lasts exactly one cycle and restarts the window. With the queue still non-empty and unread, the next pulse follows ten edges later.
- R10: The watchdogs are independent. A port that is read or empty never flushes because another port times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_strobe | input | 1 | Header present; capture destination |
| hdr_addr | input | 2 | Destination port number from header low bits |
| wr_req | input | 1 | Controller asks to write current byte |
| fifo_full | input | 4 | Full flag of each output queue |
| fifo_empty | input | 4 | Empty flag of each output queue |
| rd_en | input | 4 | Read enable from each receiver |
| fifo_we | output | 4 | Write enable to each queue |
| full_out | output | 1 | Full flag of the selected queue |
| vld_out | output | 4 | Data available toward each receiver |
| flush | output | 4 | One-cycle soft reset of each queue |

## Verification
The hardest situations to reach are the edges of the timeout window. A read or an empty cycle landing one edge before expiry must push the pulse a full ten edges further. Two ports must also count in step while only one of them expires. The directed tests hold the empty and read inputs of chosen ports for exact edge counts from a cleared counter. They break the run with a single read, a single empty cycle, or a mid-window reset. Then they probe the flush outputs at every edge around the expected pulse.

// File: rtl/psync_pkg.sv
package psync_pkg;

  // Watchdog expiry test: port holds data, no read, and the window is used up.
  function automatic logic wd_expire(input logic [15:0] count, input int unsigned limit,
                                     input logic valid, input logic read);
    return valid && !read && (count == 16'(limit - 1));
  endfunction

  // Next count: restart on read, empty or expiry, otherwise advance.
  function automatic logic [15:0] wd_next(input logic [15:0] count, input logic valid,
                                          input logic read, input logic expire);
    if (!valid || read || expire) return 16'd0;
    return count + 16'd1;
  endfunction

endpackage

// File: rtl/psync_dest.sv
module psync_dest #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_strobe,
  input  logic [ADDR_W-1:0]    hdr_addr,
  input  logic                 wr_req,
  input  logic [NUM_PORTS-1:0] fifo_full,
  output logic [NUM_PORTS-1:0] fifo_we,
  output logic                 full_out,
  output logic [ADDR_W-1:0]    dest_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)           dest_q <= '0;
    else if (addr_strobe) dest_q <= hdr_addr;
  end

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++)
      fifo_we[i] = wr_req && (dest_q == ADDR_W'(i));
  end

  assign full_out = fifo_full[dest_q];

  // R2: destination holds when no strobe was seen at the previous edge
  a_r2_dest_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(addr_strobe)) |-> $stable(dest_q));

  // R3: no write enable without a request
  a_r3_we_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |-> (fifo_we == '0));

endmodule

// File: rtl/psync_watchdog.sv
module psync_watchdog
  import psync_pkg::*;
#(
  parameter int TIMEOUT = 10,
  parameter int CNT_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic rd_en,
  output logic flush_q
);

  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  logic [15:0]      cnt_nx;

  assign expire = wd_expire(16'(cnt_q), TIMEOUT, vld, rd_en);
  assign cnt_nx = wd_next(16'(cnt_q), vld, rd_en, expire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx[CNT_W-1:0];
      flush_q <= expire;
    end
  end

  // R9: a flush pulse is one cycle wide
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |=> !flush_q);

  // R6: a pulse follows only an unread cycle with data
  a_r6_needs_wait: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && flush_q) |-> $past(vld && !rd_en));

  // R7: a read blocks the next pulse
  a_r7_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !flush_q);

  // R8: an empty queue blocks the next pulse
  a_r8_empty_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> !flush_q);

endmodule

// File: rtl/port_sync.sv
module port_sync #(
  parameter int NUM_PORTS = 4,
  parameter int TIMEOUT   = 10,
  localparam int ADDR_W   = $clog2(NUM_PORTS),
  localparam int CNT_W    = $clog2(TIMEOUT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_strobe,
  input  logic [ADDR_W-1:0]    hdr_addr,
  input  logic                 wr_req,
  input  logic [NUM_PORTS-1:0] fifo_full,
  input  logic [NUM_PORTS-1:0] fifo_empty,
  input  logic [NUM_PORTS-1:0] rd_en,
  output logic [NUM_PORTS-1:0] fifo_we,
  output logic                 full_out,
  output logic [NUM_PORTS-1:0] vld_out,
  output logic [NUM_PORTS-1:0] flush
);

  logic [ADDR_W-1:0] dest_q;

  psync_dest #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) dest_i (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .hdr_addr(hdr_addr),
    .wr_req(wr_req), .fifo_full(fifo_full), .fifo_we(fifo_we),
    .full_out(full_out), .dest_q(dest_q)
  );

  assign vld_out = ~fifo_empty;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_wd
    psync_watchdog #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) wd_i (
      .clk(clk), .rst_n(rst_n), .vld(vld_out[p]), .rd_en(rd_en[p]),
      .flush_q(flush[p])
    );
  end

  // R3: at most one queue is written per cycle
  a_r3_we_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_we));

  // R3: a request always reaches exactly one queue
  a_r3_we_present: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ($countones(fifo_we) == 1));

  // R1: no flush in the cycle following reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (flush == '0));

endmodule

// File: tb/port_sync_tb_top.sv
module port_sync_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_strobe = 1'b0;
  logic [1:0] hdr_addr = '0;
  logic       wr_req = 1'b0;
  logic [3:0] fifo_full = '0;
  logic [3:0] fifo_empty = 4'hF;
  logic [3:0] rd_en = '0;
  logic [3:0] fifo_we;
  logic       full_out;
  logic [3:0] vld_out;
  logic [3:0] flush;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_sync dut_i (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .hdr_addr(hdr_addr),
    .wr_req(wr_req), .fifo_full(fifo_full), .fifo_empty(fifo_empty), .rd_en(rd_en),
    .fifo_we(fifo_we), .full_out(full_out), .vld_out(vld_out), .flush(flush)
  );

  // vector: strobe, addr, wr, full, empty | exp_we, exp_full, exp_vld
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 2'd2, 1'b1, 4'b0100, 4'b1111, 4'b0100, 1'b1, 4'b0000},
    {1'b0, 2'd3, 1'b1, 4'b0000, 4'b1110, 4'b0100, 1'b0, 4'b0001},
    {1'b1, 2'd1, 1'b0, 4'b0010, 4'b0101, 4'b0000, 1'b1, 4'b1010},
    {1'b0, 2'd0, 1'b1, 4'b1101, 4'b0000, 4'b0010, 1'b0, 4'b1111},
    {1'b1, 2'd3, 1'b1, 4'b1000, 4'b1011, 4'b1000, 1'b1, 4'b0100},
    {1'b1, 2'd0, 1'b1, 4'b1110, 4'b1111, 4'b0001, 1'b0, 4'b0000},
    {1'b1, 2'd1, 1'b0, 4'b0000, 4'b1111, 4'b0000, 1'b0, 4'b0000},
    {1'b0, 2'd2, 1'b1, 4'b0010, 4'b0110, 4'b0010, 1'b1, 4'b1001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // run n edges from cleared count with flush check on given port; expect pulse at edge n==hit
  task automatic run_window(input string req, input int n, input int hit, input logic [3:0] pmask);
    for (int k = 1; k <= n; k++) begin
      step();
      chk(req, {28'd0, flush}, (k == hit) ? {28'd0, pmask} : 32'd0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wr_req = 1'b1;
    step();
    step();
    // R1: reset state
    chk("R1 flush in reset", {28'd0, flush}, 32'd0);
    chk("R1 dest after reset", {28'd0, fifo_we}, 32'd1);
    rst_n = 1'b1;
    step();
    chk("R1 dest after release", {28'd0, fifo_we}, 32'd1);
    chk("R1 flush after release", {28'd0, flush}, 32'd0);

    // table walk: R2 R3 R4 R5
    rd_en = 4'hF;
    for (int v = 0; v < NVEC; v++) begin
      {addr_strobe, hdr_addr, wr_req, fifo_full, fifo_empty} = VEC[v][22:9];
      step();
      chk("R2/R3 write steer", {28'd0, fifo_we}, {28'd0, VEC[v][8:5]});
      chk("R4 full select", {31'd0, full_out}, {31'd0, VEC[v][4]});
      chk("R5 valid", {28'd0, vld_out}, {28'd0, VEC[v][3:0]});
      chk("R7 no flush while read", {28'd0, flush}, 32'd0);
    end
    addr_strobe = 1'b0;
    wr_req = 1'b0;
    // R3: idle request
    step();
    chk("R3 idle", {28'd0, fifo_we}, 32'd0);

    // R6 and R9: port 0 unread
    rd_en = 4'h0; fifo_empty = 4'hF;
    step();
    fifo_empty = 4'b1110;
    run_window("R6 port0 timeout", 10, 10, 4'b0001);
    run_window("R9 second pulse", 10, 10, 4'b0001);

    // R7: read at edge 8 restarts
    fifo_empty = 4'hF; step();
    fifo_empty = 4'b1101;
    run_window("R7 before read", 7, 0, 4'b0010);
    rd_en = 4'b0010; step();
    chk("R7 read edge", {28'd0, flush}, 32'd0);
    rd_en = 4'b0000;
    run_window("R7 after read", 11, 10, 4'b0010);

    // R8: empty cycle at edge 9 restarts
    fifo_empty = 4'hF; step();
    fifo_empty = 4'b1011;
    run_window("R8 before empty", 8, 0, 4'b0100);
    fifo_empty = 4'hF; step();
    chk("R8 empty edge", {28'd0, flush}, 32'd0);
    fifo_empty = 4'b1011;
    run_window("R8 after empty", 10, 10, 4'b0100);

    // R10: ports 0 and 3 hold data, only port 3 read
    fifo_empty = 4'hF; step();
    fifo_empty = 4'b0110; rd_en = 4'b1000;
    run_window("R10 independent", 10, 10, 4'b0001);

    // R1: reset mid-window clears count
    fifo_empty = 4'hF; rd_en = 4'h0; step();
    fifo_empty = 4'b1110;
    run_window("R1 pre reset", 8, 0, 4'b0001);
    rst_n = 1'b0; step();
    chk("R1 reset mid window", {28'd0, flush}, 32'd0);
    rst_n = 1'b1;
    run_window("R1 post reset", 10, 10, 4'b0001);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule